// File: doc/BRIEF.md
# Dual-byte longitudinal parity accumulator

This block keeps a running bytewise XOR (longitudinal parity) over every data byte that a parallel bus core moves, whether the core is sending or receiving. The core raises one strobe per transfer and says whether the transfer is narrow (one byte) or wide (two bytes). The running value is a 16-bit word built from a low byte and a high byte. When the bytes of a block are followed by their correct even-parity check byte, the accumulated value returns to zero, provided it started at zero.

The host sees the word through one 8-bit register. Two view-control inputs choose what a read returns. With the split bit low, the read gives the two halves folded together by XOR. With the split bit high, the upper-select bit picks either the low half or the high half. The host can also write the register, and the same two bits decide which half the write loads. A synchronous clear and the active-low reset both zero the word.

Top module: `lpar_top`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, the whole 16-bit word is zero. `clr` overrides a host write and a transfer in the same cycle.
- R2: With `split_view` = 0, `rd_data` equals the low byte XOR the high byte.
- R3: With `split_view` = 1 and `upper_sel` = 0, `rd_data` equals the low byte.
- R4: With `split_view` = 1 and `upper_sel` = 1, `rd_data` equals the high byte.
- R5: A narrow transfer (`xfer_valid` = 1, `xfer_wide` = 0) XORs `xfer_data[7:0]` into the low byte; the high byte and `xfer_data[15:8]` are left out.
- R6: A wide transfer (`xfer_wide` = 1) XORs `xfer_data[7:0]` into the low byte and `xfer_data[15:8]` into the high byte in the same cycle.
- R7: Starting from zero, a run of transfers ending with its correct even-parity check byte (per lane) leaves the word at zero.
- R8: A host write with `split_view` = 1 loads `host_wdata` into the half picked by `upper_sel` (0 = low, 1 = high) and keeps the other half.
- R9: A host write with `split_view` = 0 loads `host_wdata` into the low byte and clears the high byte.
- R10: When a host write and a transfer occur in the same cycle, the write result is stored and the transfer bytes are not accumulated.
- R11: `rd_data` is combinational from the stored word and the two view bits; changing the view bits changes `rd_data` in the same cycle and leaves the word unchanged.
- R12: With no clear, no write and no transfer, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, zeroes the word |
| clr | input | 1 | Synchronous clear of the word |
| xfer_valid | input | 1 | One data transfer (send or receive) this cycle |
| xfer_wide | input | 1 | 1 = two-byte transfer, 0 = one-byte transfer |
| xfer_data | input | 16 | Transfer data; bits 7:0 low lane, 15:8 high lane |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | 8 | Host write data |
| split_view | input | 1 | 0 = folded view and full write, 1 = single-half view and write |
| upper_sel | input | 1 | With split_view = 1: 0 = low half, 1 = high half |
| rd_data | output | 8 | Register read value |

## Verification
The hardest situation to reach is a host write landing in the same cycle as a wide transfer whose bytes would visibly corrupt both halves, because only then does losing the priority show at the read port. The stimulus first sets distinct values in the two halves by writes, then issues a high-half write together with an all-ones wide transfer and reads each half separately, so an accumulated transfer or a wrong half shows as a changed byte. The same cycle is then repeated with the clear raised to show that it overrides both.

// File: rtl/lpar_pkg.sv
package lpar_pkg;

    // How a read is formed from the stored word
    typedef enum logic [1:0] {
        VIEW_FOLD = 2'd0,
        VIEW_LOW  = 2'd1,
        VIEW_HIGH = 2'd2
    } lpar_view_e;

    // What the accumulator does in a cycle, highest priority first
    typedef enum logic [1:0] {
        ACC_HOLD  = 2'd0,
        ACC_CLEAR = 2'd1,
        ACC_LOAD  = 2'd2,
        ACC_XOR   = 2'd3
    } lpar_op_e;

    function automatic lpar_view_e view_decode(input logic split, input logic upper);
        if (!split)
            return VIEW_FOLD;
        else if (upper)
            return VIEW_HIGH;
        else
            return VIEW_LOW;
    endfunction

    function automatic lpar_op_e pick_op(input logic clr, input logic wr, input logic xv);
        if (clr)
            return ACC_CLEAR;
        else if (wr)
            return ACC_LOAD;
        else if (xv)
            return ACC_XOR;
        else
            return ACC_HOLD;
    endfunction

endpackage

// File: rtl/lpar_accum.sv
module lpar_accum #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                xfer_valid,
    input  logic                xfer_wide,
    input  logic [2*BYTE_W-1:0] xfer_data,
    input  logic                host_wr,
    input  logic [BYTE_W-1:0]   host_wdata,
    input  logic                split_view,
    input  logic                upper_sel,
    output logic [BYTE_W-1:0]   lo_o,
    output logic [BYTE_W-1:0]   hi_o
);
    import lpar_pkg::*;

    localparam int LANES = 2;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } word_t;

    word_t    state_d, state_q;
    lpar_op_e op_d;

    logic [LANES-1:0]  lane_on;
    logic [BYTE_W-1:0] lane_term [LANES];

    assign lane_on = {xfer_wide, 1'b1};

    // Per-lane gated transfer byte
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_term[g] = lane_on[g] ? xfer_data[g*BYTE_W +: BYTE_W] : '0;
    end

    always_comb begin
        state_d = state_q;
        op_d    = pick_op(clr, host_wr, xfer_valid);
        case (op_d)
            ACC_CLEAR: state_d = '0;
            ACC_LOAD: begin
                if (split_view) begin
                    if (upper_sel)
                        state_d.hi = host_wdata;
                    else
                        state_d.lo = host_wdata;
                end else begin
                    state_d.lo = host_wdata;
                    state_d.hi = '0;
                end
            end
            ACC_XOR: begin
                state_d.lo = state_q.lo ^ lane_term[0];
                state_d.hi = state_q.hi ^ lane_term[1];
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign lo_o = state_q.lo;
    assign hi_o = state_q.hi;

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lo_o == '0 && hi_o == '0));

    // R5
    narrow_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_wide && !host_wr && !clr) |=>
        (lo_o == ($past(lo_o) ^ $past(xfer_data[BYTE_W-1:0])) && $stable(hi_o)));

    // R6
    wide_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_wide && !host_wr && !clr) |=>
        (lo_o == ($past(lo_o) ^ $past(xfer_data[BYTE_W-1:0])) &&
         hi_o == ($past(hi_o) ^ $past(xfer_data[2*BYTE_W-1:BYTE_W]))));

    // R8 R10
    split_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !clr && split_view) |=>
        ($past(upper_sel) ? (hi_o == $past(host_wdata) && $stable(lo_o))
                          : (lo_o == $past(host_wdata) && $stable(hi_o))));

    // R9 R10
    full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !clr && !split_view) |=>
        (lo_o == $past(host_wdata) && hi_o == '0));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_valid && !host_wr && !clr) |=> ($stable(lo_o) && $stable(hi_o)));

endmodule

// File: rtl/lpar_view.sv
module lpar_view #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic              split_view,
    input  logic              upper_sel,
    output logic [BYTE_W-1:0] rd_o
);
    import lpar_pkg::*;

    lpar_view_e view_sel;

    always_comb begin
        view_sel = view_decode(split_view, upper_sel);
        case (view_sel)
            VIEW_LOW:  rd_o = lo_i;
            VIEW_HIGH: rd_o = hi_i;
            default:   rd_o = lo_i ^ hi_i;
        endcase
    end

endmodule

// File: rtl/lpar_top.sv
module lpar_top #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                xfer_valid,
    input  logic                xfer_wide,
    input  logic [2*BYTE_W-1:0] xfer_data,
    input  logic                host_wr,
    input  logic [BYTE_W-1:0]   host_wdata,
    input  logic                split_view,
    input  logic                upper_sel,
    output logic [BYTE_W-1:0]   rd_data
);

    logic [BYTE_W-1:0] acc_lo, acc_hi;

    lpar_accum #(.BYTE_W(BYTE_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .xfer_valid (xfer_valid),
        .xfer_wide  (xfer_wide),
        .xfer_data  (xfer_data),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .split_view (split_view),
        .upper_sel  (upper_sel),
        .lo_o       (acc_lo),
        .hi_o       (acc_hi)
    );

    lpar_view #(.BYTE_W(BYTE_W)) u_view (
        .lo_i       (acc_lo),
        .hi_i       (acc_hi),
        .split_view (split_view),
        .upper_sel  (upper_sel),
        .rd_o       (rd_data)
    );

    // R2 R7
    fold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_view && acc_lo == acc_hi) |-> (rd_data == '0));

    // R3
    low_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split_view && !upper_sel) |-> (rd_data == acc_lo));

    // R4
    high_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split_view && upper_sel) |-> (rd_data == acc_hi));

endmodule

// File: tb/lpar_top_test.sv
`timescale 1ns/1ps
module lpar_top_test;

    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          xfer_valid = 1'b0;
    logic          xfer_wide = 1'b0;
    logic [15:0]   xfer_data = '0;
    logic          host_wr = 1'b0;
    logic [BW-1:0] host_wdata = '0;
    logic          split_view = 1'b0;
    logic          upper_sel = 1'b0;
    logic [BW-1:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lpar_top #(.BYTE_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .xfer_valid(xfer_valid), .xfer_wide(xfer_wide), .xfer_data(xfer_data),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .split_view(split_view), .upper_sel(upper_sel), .rd_data(rd_data)
    );

    // op: 0 idle, 1 transfer, 2 host write
    typedef struct packed {
        logic [1:0]  op;
        logic        wide;
        logic [15:0] data;
        logic        ws;
        logic        wu;
        logic        rs;
        logic        ru;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 16'hEE12, 1'b0, 1'b0, 1'b0, 1'b0, 8'h12, 8'd5 },  // R5 narrow, upper lane ignored
        '{2'd1, 1'b0, 16'h0034, 1'b0, 1'b0, 1'b1, 1'b0, 8'h26, 8'd3 },  // R3 low view
        '{2'd1, 1'b1, 16'hA55A, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 8'd6 },  // R6 wide, R4 high view
        '{2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hD9, 8'd2 },  // R2 fold 7C^A5
        '{2'd1, 1'b1, 16'hA57C, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'd7 },  // R7 wide check word
        '{2'd1, 1'b0, 16'h770F, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0F, 8'd5 },  // R5
        '{2'd1, 1'b0, 16'h00F0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'd2 },  // R2 high still zero
        '{2'd1, 1'b0, 16'h00FF, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'd7 },  // R7 narrow check byte
        '{2'd2, 1'b0, 16'h003C, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 8'd8 },  // R8 high half
        '{2'd2, 1'b0, 16'h00C3, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'd8 },  // R8 low half, high kept
        '{2'd2, 1'b0, 16'h0081, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'd9 },  // R9 high cleared
        '{2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 8'd12}   // R12 hold
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%02h expected %02h", req, act, exp);
        end
    endtask

    // Set view bits between clock edges and sample the combinational read
    task automatic view_check(input logic s, input logic u, input logic [7:0] exp, input string req);
        split_view = s;
        upper_sel  = u;
        #1;
        check(rd_data, exp, req);
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, all views
        view_check(1'b0, 1'b0, 8'h00, "R1");
        view_check(1'b1, 1'b0, 8'h00, "R1");
        view_check(1'b1, 1'b1, 8'h00, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            xfer_valid = (VECS[i].op == 2'd1);
            xfer_wide  = VECS[i].wide;
            xfer_data  = VECS[i].data;
            host_wr    = (VECS[i].op == 2'd2);
            host_wdata = VECS[i].data[7:0];
            split_view = VECS[i].ws;
            upper_sel  = VECS[i].wu;
            @(negedge clk);
            xfer_valid = 1'b0;
            host_wr    = 1'b0;
            view_check(VECS[i].rs, VECS[i].ru, VECS[i].exp, $sformatf("R%0d", VECS[i].req));
        end

        // R10: write high half with an all-ones wide transfer in the same cycle
        host_wr    = 1'b1;
        host_wdata = 8'h55;
        split_view = 1'b1;
        upper_sel  = 1'b1;
        xfer_valid = 1'b1;
        xfer_wide  = 1'b1;
        xfer_data  = 16'hFFFF;
        @(negedge clk);
        host_wr    = 1'b0;
        xfer_valid = 1'b0;
        view_check(1'b1, 1'b0, 8'h81, "R10");
        view_check(1'b1, 1'b1, 8'h55, "R10");

        // R11: view changes without a clock edge, word untouched
        view_check(1'b0, 1'b0, 8'hD4, "R11");
        view_check(1'b1, 1'b1, 8'h55, "R11");
        @(negedge clk);
        view_check(1'b1, 1'b0, 8'h81, "R11");

        // R1: clear beats write and transfer in the same cycle
        clr        = 1'b1;
        host_wr    = 1'b1;
        host_wdata = 8'hAA;
        split_view = 1'b0;
        xfer_valid = 1'b1;
        xfer_data  = 16'h1234;
        @(negedge clk);
        clr        = 1'b0;
        host_wr    = 1'b0;
        xfer_valid = 1'b0;
        view_check(1'b1, 1'b0, 8'h00, "R1");
        view_check(1'b1, 1'b1, 8'h00, "R1");
        view_check(1'b0, 1'b0, 8'h00, "R1");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

endmodule